// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a small sum-of-products logic cell whose function is set by loaded configuration bits rather than by fixed gates. Each primary input is offered to a grid of product-term rows in both its true and its inverted form. One configuration bit per crossing decides whether that literal joins the row's AND. A per-row enable decides whether the row feeds the output. The OR that combines the rows is fixed. The array evaluates combinationally. A configuration bit can instead send the result through an output flip-flop.

Configuration is loaded serially while a load strobe is high, one bit per clock. During loading the output is forced low. Once the strobe drops, the configuration stays frozen and the array behaves as the programmed function. The number of inputs and rows are parameters. An elaboration parameter removes the output flip-flop entirely.

Top module: `pal_array`

## Requirements
- R1: Input `i` drives literal column `2i` in true form and column `2i+1` in inverted form.
- R2: Within a row word, bit `c` (for c < 2·NUM_IN) set means literal column `c` takes part in that row's AND. A row with both forms of one input selected is never true.
- R3: An enabled row with no literal selected evaluates to 0.
- R4: Bit `2·NUM_IN` of a row word is its enable. The output is the OR of the enabled rows only, and a disabled row has no effect on the output.
- R5: Configuration is shifted in on `cfg_bit`, one bit per rising edge while `load_en` is high. The first bit sent is the output-register select. Rows follow from the highest index down, and within each row the bits go from the enable bit down to column 0. While `load_en` is low, `cfg_bit` has no effect.
- R6: `out_y` is 0 whenever `load_en` is high.
- R7: Row 0 = {in0, in1}, row 1 = {~in0, in2}, row 2 disabled gives `out_y` = in1 when in0=1 and in2 when in0=0.
- R8: With the output-register select bit set to 1, `out_y` follows the sum of products one rising edge later. With it set to 0, `out_y` follows the sum of products in the same cycle.
- R9: Reset (`rst_n` low) clears all configuration, so `out_y` is 0 for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration shifting and the output flip-flop |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | High while configuration bits are shifted in |
| cfg_bit | input | 1 | Serial configuration data |
| in_vec | input | NUM_IN | Primary inputs |
| out_y | output | 1 | Sum-of-products result |

## Verification
Three-input patterns are applied to several programmed functions: a 2:1 selector, a three-way AND, a two-input XOR, a single inverted literal, an empty row, a disabled row, and a row holding both forms of one input. The selector tells the true columns apart from the inverted ones. The XOR shows that separate rows combine by OR. The inverted-literal case checks the column placement. The empty, disabled and contradictory rows each produce a constant 0 that a wrong enable or mask polarity would break. Directed tests cover the reset state, the output held at 0 mid-load, `cfg_bit` toggled with the strobe low, and the one-cycle lag in registered mode.

// File: rtl/pal_pkg.sv
package pal_pkg;
   // width of one product-term row word: two literal columns per input plus enable
   function automatic int row_word_width(input int n_in);
      return 2 * n_in + 1;
   endfunction

   // total serial configuration length: all rows plus the output-register select bit
   function automatic int cfg_length(input int n_in, input int n_rows);
      return n_rows * row_word_width(n_in) + 1;
   endfunction
endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
   parameter int CFG_BITS = 22
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_en,
   input  logic                ser_in,
   output logic [CFG_BITS-1:0] cfg_q
);
   generate
      if (CFG_BITS < 2) begin : g_bad_len
         $error("pal_cfg_chain: CFG_BITS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (shift_en) begin
         cfg_q <= {cfg_q[CFG_BITS-2:0], ser_in};
      end
   end
endmodule

// File: rtl/pal_literals.sv
module pal_literals #(
   parameter int NUM_IN = 3,
   localparam int NUM_LIT = 2 * NUM_IN
) (
   input  logic [NUM_IN-1:0]  in_vec,
   output logic [NUM_LIT-1:0] lits
);
   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
         assign lits[2*i]   = in_vec[i];
         assign lits[2*i+1] = ~in_vec[i];
      end
   endgenerate
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane
   import pal_pkg::*;
#(
   parameter int NUM_IN   = 3,
   parameter int NUM_ROWS = 3,
   localparam int NUM_LIT  = 2 * NUM_IN,
   localparam int ROW_W    = row_word_width(NUM_IN),
   localparam int PLANE_W  = NUM_ROWS * ROW_W
) (
   input  logic [NUM_LIT-1:0]  lits,
   input  logic [PLANE_W-1:0]  plane_cfg,
   output logic [NUM_ROWS-1:0] row_hit
);
   generate
      for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
         logic [ROW_W-1:0]   word;
         logic [NUM_LIT-1:0] mask;
         logic               en;
         logic               all_true;
         logic               any_sel;

         assign word     = plane_cfg[r*ROW_W +: ROW_W];
         assign mask     = word[NUM_LIT-1:0];
         assign en       = word[ROW_W-1];
         // unselected columns pass as 1, selected columns pass their literal
         assign all_true = &(lits | ~mask);
         assign any_sel  = |mask;
         assign row_hit[r] = en & any_sel & all_true;
      end
   endgenerate
endmodule

// File: rtl/pal_or_stage.sv
module pal_or_stage #(
   parameter int NUM_ROWS   = 3,
   parameter bit REG_OPTION = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_ROWS-1:0] row_hit,
   input  logic                load_en,
   input  logic                use_reg,
   output logic                sum_or,
   output logic                out_y
);
   assign sum_or = |row_hit;

   generate
      if (REG_OPTION) begin : g_reg
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= 1'b0;
            end else begin
               q <= load_en ? 1'b0 : sum_or;
            end
         end
         assign out_y = load_en ? 1'b0 : (use_reg ? q : sum_or);
      end else begin : g_noreg
         logic unused_sel;
         assign unused_sel = use_reg ^ clk ^ rst_n;
         assign out_y = load_en ? 1'b0 : sum_or;
      end
   endgenerate
endmodule

// File: rtl/pal_array.sv
module pal_array
   import pal_pkg::*;
#(
   parameter int NUM_IN     = 3,
   parameter int NUM_ROWS   = 3,
   parameter bit REG_OPTION = 1'b1,
   localparam int NUM_LIT   = 2 * NUM_IN,
   localparam int ROW_W     = row_word_width(NUM_IN),
   localparam int PLANE_W   = NUM_ROWS * ROW_W,
   localparam int CFG_BITS  = cfg_length(NUM_IN, NUM_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              cfg_bit,
   input  logic [NUM_IN-1:0] in_vec,
   output logic              out_y
);
   generate
      if (NUM_IN < 1 || NUM_IN > 16) begin : g_bad_in
         $error("pal_array: NUM_IN out of range 1..16");
      end
      if (NUM_ROWS < 1 || NUM_ROWS > 64) begin : g_bad_rows
         $error("pal_array: NUM_ROWS out of range 1..64");
      end
   endgenerate

   logic [CFG_BITS-1:0] cfg_q;
   logic [NUM_LIT-1:0]  lits;
   logic [NUM_ROWS-1:0] row_hit;
   logic                sum_or;
   logic                use_reg;

   assign use_reg = cfg_q[CFG_BITS-1];

   pal_cfg_chain #(.CFG_BITS(CFG_BITS)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (load_en),
      .ser_in   (cfg_bit),
      .cfg_q    (cfg_q)
   );

   pal_literals #(.NUM_IN(NUM_IN)) u_lits (
      .in_vec (in_vec),
      .lits   (lits)
   );

   pal_and_plane #(.NUM_IN(NUM_IN), .NUM_ROWS(NUM_ROWS)) u_and (
      .lits      (lits),
      .plane_cfg (cfg_q[PLANE_W-1:0]),
      .row_hit   (row_hit)
   );

   pal_or_stage #(.NUM_ROWS(NUM_ROWS), .REG_OPTION(REG_OPTION)) u_or (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_hit (row_hit),
      .load_en (load_en),
      .use_reg (use_reg),
      .sum_or  (sum_or),
      .out_y   (out_y)
   );
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
   parameter int NUM_IN     = 3,
   parameter int NUM_ROWS   = 3,
   parameter bit REG_OPTION = 1'b1,
   localparam int NUM_LIT   = 2 * NUM_IN,
   localparam int ROW_W     = NUM_LIT + 1,
   localparam int CFG_BITS  = NUM_ROWS * ROW_W + 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                load_en,
   input logic                out_y,
   input logic [CFG_BITS-1:0] cfg_q,
   input logic [NUM_ROWS-1:0] row_hit,
   input logic                sum_or
);
   AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> !out_y); // R6

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(cfg_q)); // R5

   AST_COMB_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !cfg_q[CFG_BITS-1]) |-> (out_y == sum_or)); // R8

   generate
      for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowchk
         AST_ROW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_q[r*ROW_W + ROW_W - 1] |-> !row_hit[r]); // R4
         AST_EMPTY_ROW: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[r*ROW_W +: NUM_LIT] == '0) |-> !row_hit[r]); // R3
      end
      if (REG_OPTION) begin : g_regchk
         AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[CFG_BITS-1] && !load_en && $past(!load_en))
               |-> (out_y == $past(sum_or))); // R8
      end
   endgenerate
endmodule

bind pal_array pal_array_chk #(
   .NUM_IN     (NUM_IN),
   .NUM_ROWS   (NUM_ROWS),
   .REG_OPTION (REG_OPTION)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .load_en (load_en),
   .out_y   (out_y),
   .cfg_q   (cfg_q),
   .row_hit (row_hit),
   .sum_or  (sum_or)
);

// File: tb/pal_array_test.sv
module pal_array_test;
   localparam int CFGW = 22; // 3 rows x 7 bits + register select

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_en = 1'b0;
   logic       cfg_bit = 1'b0;
   logic [2:0] in_vec = 3'b000;
   logic       out_y;
   int         checks = 0;
   int         fails = 0;

   always #4 clk = ~clk; // 125 MHz

   pal_array uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .cfg_bit (cfg_bit),
      .in_vec  (in_vec),
      .out_y   (out_y)
   );

   // row word: [6]=enable [5]=~in2 [4]=in2 [3]=~in1 [2]=in1 [1]=~in0 [0]=in0
   localparam logic [CFGW-1:0] C_MUX   = {1'b0, 7'b0, 7'b1010010, 7'b1000101};
   localparam logic [CFGW-1:0] C_AND3  = {1'b0, 7'b0, 7'b0, 7'b1010101};
   localparam logic [CFGW-1:0] C_XOR   = {1'b0, 7'b0, 7'b1000110, 7'b1001001};
   localparam logic [CFGW-1:0] C_NOT1  = {1'b0, 7'b0, 7'b0, 7'b1001000};
   localparam logic [CFGW-1:0] C_EMPTY = {1'b0, 7'b0, 7'b0, 7'b1000000};
   localparam logic [CFGW-1:0] C_DIS   = {1'b0, 7'b0, 7'b1010000, 7'b0000001};
   localparam logic [CFGW-1:0] C_CONTR = {1'b0, 7'b0, 7'b0, 7'b1000011};
   localparam logic [CFGW-1:0] C_MUXR  = {1'b1, 7'b0, 7'b1010010, 7'b1000101};

   // entry: {requirement number, config, inputs {in2,in1,in0}, expected out}
   localparam int NV = 24;
   localparam logic [29:0] VEC [0:NV-1] = '{
      {4'd7, C_MUX,   3'b000, 1'b0},  // R7 sel=0 -> in2
      {4'd7, C_MUX,   3'b001, 1'b0},  // R7 sel=1 -> in1
      {4'd7, C_MUX,   3'b010, 1'b0},  // R7
      {4'd7, C_MUX,   3'b011, 1'b1},  // R7
      {4'd7, C_MUX,   3'b100, 1'b1},  // R7
      {4'd7, C_MUX,   3'b101, 1'b0},  // R7
      {4'd7, C_MUX,   3'b110, 1'b1},  // R7
      {4'd7, C_MUX,   3'b111, 1'b1},  // R7
      {4'd2, C_AND3,  3'b111, 1'b1},  // R2 all literals true
      {4'd2, C_AND3,  3'b011, 1'b0},  // R2
      {4'd2, C_AND3,  3'b110, 1'b0},  // R2
      {4'd4, C_XOR,   3'b000, 1'b0},  // R4 OR of two rows
      {4'd4, C_XOR,   3'b001, 1'b1},  // R4
      {4'd4, C_XOR,   3'b010, 1'b1},  // R4
      {4'd4, C_XOR,   3'b011, 1'b0},  // R4
      {4'd1, C_NOT1,  3'b000, 1'b1},  // R1 column 3 is ~in1
      {4'd1, C_NOT1,  3'b010, 1'b0},  // R1
      {4'd3, C_EMPTY, 3'b000, 1'b0},  // R3 empty row
      {4'd3, C_EMPTY, 3'b111, 1'b0},  // R3
      {4'd4, C_DIS,   3'b001, 1'b0},  // R4 disabled row ignored
      {4'd4, C_DIS,   3'b101, 1'b1},  // R4
      {4'd4, C_DIS,   3'b100, 1'b1},  // R4
      {4'd2, C_CONTR, 3'b001, 1'b0},  // R2 in0 and ~in0
      {4'd2, C_CONTR, 3'b110, 1'b0}   // R2
   };

   task automatic check(input logic exp, input string req);
      checks++;
      if (out_y !== exp) begin
         fails++;
         $display("FAIL %s: out_y=%b expected=%b at %0t", req, out_y, exp, $time);
      end
   endtask

   // shifts the word in, first bit = MSB; checks the output mid-load (R6)
   task automatic load_cfg(input logic [CFGW-1:0] w);
      @(negedge clk);
      load_en = 1'b1;
      for (int i = CFGW - 1; i >= 0; i--) begin
         cfg_bit = w[i];
         @(negedge clk);
         if (i == CFGW / 2) check(1'b0, "R6");
      end
      load_en = 1'b0;
      cfg_bit = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [CFGW-1:0] cur;
      // R9: reset clears configuration
      repeat (3) @(negedge clk);
      in_vec = 3'b111;
      #1 check(1'b0, "R9");
      rst_n = 1'b1;
      @(negedge clk);
      in_vec = 3'b010;
      #1 check(1'b0, "R9");

      cur = '1;
      for (int k = 0; k < NV; k++) begin
         if (VEC[k][25:4] != cur) begin
            cur = VEC[k][25:4];
            load_cfg(cur);
         end
         @(negedge clk);
         in_vec = VEC[k][3:1];
         #1 check(VEC[k][0], $sformatf("R%0d vector %0d", VEC[k][29:26], k));
      end

      // R5: cfg_bit toggling with load_en low leaves the mux intact
      load_cfg(C_MUX);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         cfg_bit = ~cfg_bit;
      end
      cfg_bit = 1'b0;
      in_vec = 3'b011;
      #1 check(1'b1, "R5 frozen config, sel=1 in1=1");
      in_vec = 3'b100;
      #1 check(1'b1, "R5 frozen config, sel=0 in2=1");
      in_vec = 3'b101;
      #1 check(1'b0, "R5 frozen config, sel=1 in1=0");

      // R8: registered mode lags by one rising edge
      load_cfg(C_MUXR);
      @(negedge clk);
      in_vec = 3'b011;
      #1 check(1'b0, "R8 registered, before edge");
      @(posedge clk);
      #1 check(1'b1, "R8 registered, after edge");
      @(negedge clk);
      in_vec = 3'b001;
      #1 check(1'b1, "R8 registered, hold before edge");
      @(posedge clk);
      #1 check(1'b0, "R8 registered, falls after edge");

      // R6: reloading in registered mode still forces 0
      @(negedge clk);
      in_vec = 3'b011;
      @(posedge clk);
      #1 check(1'b1, "R8 registered high before reload");
      load_cfg(C_MUX);
      @(negedge clk);
      in_vec = 3'b011;
      #1 check(1'b1, "R8 combinational after reload");

      // R9: reset mid-operation clears configuration
      rst_n = 1'b0;
      #1 check(1'b0, "R9 reset mid-operation");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1 check(1'b0, "R9 after reset release");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule